// File: doc/BRIEF.md
# Shadow-Tag Cache Interference Detector

This block estimates how many extra memory cycles each core loses because other cores share its last-level cache. For every core it keeps a private shadow tag directory. The directory holds only tags and valid bits, and it records what that core's cache set contents would be if the core ran alone. Only the core's own accesses update its directory. Each directory has the same number of sets and the same associativity as the shared cache, and it replaces blocks in least-recently-used order.

On each access strobe the block looks up the requesting core's shadow directory and compares the result with the hit or miss that the shared cache reports. A shared miss that the shadow directory would have served is interference. The block then adds the programmed miss penalty, in clock cycles, to that core's saturating accumulator. Interference totals in cycles can be summed directly with delay estimates taken from other shared units.

When another core evicts a line, nothing is charged at that moment. A cost is charged only if the owner later misses on that line while its shadow directory still holds it.

Top module: `sit_intf_detector`

## Requirements
- R1: After reset, every interference total reads 0, `class_o` reads 0 (idle) and the penalty register holds `PEN_RST`.
- R2: `class_o` shows the result of an access one clock after the strobe is sampled. The encoding is: 0 = no access, 1 = shared-cache hit, 2 = interference (shared miss and shadow hit), 3 = shared miss and shadow miss.
- R3: An interference access adds the penalty register value to the requesting core's total. The totals of all other cores do not change.
- R4: A shared-cache hit adds no cost, even when the shadow directory misses. The shadow directory still allocates the line, so a later shared miss on that line counts as interference.
- R5: A core's shadow directory changes only on that core's own accesses. When another core touches the same line, the owner's shadow hits are unchanged and no cost is charged to the owner.
- R6: Each shadow set holds WAYS tags. A shadow miss fills the lowest-numbered invalid way. If no way is invalid, it replaces the least recently used way. Both hits and fills make a way most recently used.
- R7: Each total saturates at 2^ACC_W-1 and never wraps.
- R8: When `pen_we_i` is high at a clock edge, `pen_data_i` becomes the cost charged by accesses sampled at later edges.
- R9: Accesses on consecutive cycles are each classified and charged. A later access sees the shadow update made by the earlier one.
- R10: The address is a line address. Bits [SET_W-1:0] select the set and the upper bits form the tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pen_we_i | input | 1 | Load the penalty register |
| pen_data_i | input | PEN_W | New miss penalty, in cycles |
| acc_valid_i | input | 1 | Shared-cache access strobe |
| acc_core_i | input | CORE_W | Requesting core |
| acc_line_i | input | ADDR_W | Line address of the access |
| acc_hit_i | input | 1 | Shared-cache hit result for this access |
| class_o | output | 2 | Registered classification of the previous cycle's access |
| totals_o | output | NUM_CORES*ACC_W | Per-core interference totals; core c occupies bits [c*ACC_W +: ACC_W] |

## Verification
The bench builds the block with two cores, two sets, two ways, a 6-bit line address and 10-bit totals. With these sizes a handful of lines fills a set and forces LRU victims. A few penalty charges reach saturation. A bench-side LRU model predicts every classification and every total. A long pseudo-random sweep over a narrow address range then exercises every mix of shared and shadow outcomes, cross-core evictions and back-to-back strobes.

// File: rtl/sit_pkg.sv
package sit_pkg;
  typedef enum logic [1:0] {
    CLS_IDLE       = 2'd0,
    CLS_SHARED_HIT = 2'd1,
    CLS_INTERFERE  = 2'd2,
    CLS_COLD_MISS  = 2'd3
  } cls_e;
endpackage

// File: rtl/sit_shadow_dir.sv
module sit_shadow_dir #(
  parameter int SETS  = 16,
  parameter int WAYS  = 4,
  parameter int TAG_W = 8,
  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [SET_W-1:0] set_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic             hit_o
);
  logic             valid_q [SETS][WAYS];
  logic [TAG_W-1:0] tag_q   [SETS][WAYS];
  logic [WAY_W-1:0] age_q   [SETS][WAYS];

  logic [WAYS-1:0]  hit_vec;
  logic [WAY_W-1:0] hit_way, inv_way, lru_way, use_way, use_age;
  logic             has_inv;

  always_comb begin
    hit_way = '0;
    inv_way = '0;
    lru_way = '0;
    has_inv = 1'b0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      hit_vec[w] = valid_q[set_i][w] && (tag_q[set_i][w] == tag_i);
      if (hit_vec[w]) hit_way = WAY_W'(w);
      if (!valid_q[set_i][w]) begin
        inv_way = WAY_W'(w);
        has_inv = 1'b1;
      end
      if (age_q[set_i][w] == WAY_W'(WAYS - 1)) lru_way = WAY_W'(w);
    end
    hit_o   = |hit_vec;
    use_way = hit_o ? hit_way : (has_inv ? inv_way : lru_way);
    use_age = age_q[set_i][use_way];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) begin
          valid_q[s][w] <= 1'b0;
          tag_q[s][w]   <= '0;
          age_q[s][w]   <= WAY_W'(w);
        end
    end else if (req_i) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == use_way)         age_q[set_i][w] <= '0;
        else if (age_q[set_i][w] < use_age) age_q[set_i][w] <= age_q[set_i][w] + 1'b1;
      end
      if (!hit_o) begin
        valid_q[set_i][use_way] <= 1'b1;
        tag_q[set_i][use_way]   <= tag_i;
      end
    end
  end

  // R6: a tag lives in at most one way of a set
  a_r6_single_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |-> $onehot0(hit_vec));
endmodule

// File: rtl/sit_sat_acc.sv
module sit_sat_acc #(
  parameter int ACC_W = 32,
  parameter int PEN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             add_i,
  input  logic [PEN_W-1:0] amt_i,
  output logic [ACC_W-1:0] total_o
);
  logic [ACC_W:0] sum;

  assign sum = {1'b0, total_o} + (ACC_W + 1)'(amt_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    total_o <= '0;
    else if (add_i) total_o <= sum[ACC_W] ? {ACC_W{1'b1}} : sum[ACC_W-1:0];
  end

  a_r7_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    add_i |=> total_o >= $past(total_o));
  a_r3_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !add_i |=> $stable(total_o));
endmodule

// File: rtl/sit_intf_detector.sv
module sit_intf_detector #(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 20,
  parameter int SETS      = 16,
  parameter int WAYS      = 4,
  parameter int ACC_W     = 32,
  parameter int PEN_W     = 16,
  parameter logic [PEN_W-1:0] PEN_RST = 16'd100,
  localparam int CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int SET_W  = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int TAG_W  = ADDR_W - SET_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       pen_we_i,
  input  logic [PEN_W-1:0]           pen_data_i,
  input  logic                       acc_valid_i,
  input  logic [CORE_W-1:0]          acc_core_i,
  input  logic [ADDR_W-1:0]          acc_line_i,
  input  logic                       acc_hit_i,
  output logic [1:0]                 class_o,
  output logic [NUM_CORES*ACC_W-1:0] totals_o
);
  import sit_pkg::*;

  logic [SET_W-1:0]     acc_set;
  logic [TAG_W-1:0]     acc_tag;
  logic [NUM_CORES-1:0] sh_hit, req, charge;
  logic                 sel_hit;
  logic [PEN_W-1:0]     pen_q;
  cls_e                 cls_d, cls_q;

  assign acc_set = acc_line_i[SET_W-1:0];
  assign acc_tag = acc_line_i[ADDR_W-1:SET_W];

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    assign req[c]    = acc_valid_i && (acc_core_i == CORE_W'(c));
    assign charge[c] = req[c] && !acc_hit_i && sh_hit[c];

    sit_shadow_dir #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) i_dir (
      .clk_i, .rst_ni,
      .req_i (req[c]),
      .set_i (acc_set),
      .tag_i (acc_tag),
      .hit_o (sh_hit[c])
    );

    sit_sat_acc #(.ACC_W(ACC_W), .PEN_W(PEN_W)) i_acc (
      .clk_i, .rst_ni,
      .add_i   (charge[c]),
      .amt_i   (pen_q),
      .total_o (totals_o[c*ACC_W +: ACC_W])
    );
  end

  assign sel_hit = |(sh_hit & req);

  always_comb begin
    if (!acc_valid_i)   cls_d = CLS_IDLE;
    else if (acc_hit_i) cls_d = CLS_SHARED_HIT;
    else if (sel_hit)   cls_d = CLS_INTERFERE;
    else                cls_d = CLS_COLD_MISS;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cls_q <= CLS_IDLE;
      pen_q <= PEN_RST;
    end else begin
      cls_q <= cls_d;
      if (pen_we_i) pen_q <= pen_data_i;
    end
  end

  assign class_o = cls_q;

  a_r2_idle_class: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_i |=> class_o == CLS_IDLE);
  a_r4_hit_no_cost: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && acc_hit_i) |=> $stable(totals_o));
  a_r5_one_requester: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(charge));
endmodule

// File: tb/test_sit_intf_detector.sv
`timescale 1ns/1ps
module test_sit_intf_detector;
  localparam int NC = 2, AW = 6, NS = 2, NW = 2, ACW = 10, PW = 8;
  localparam int MAXV = (1 << ACW) - 1;

  logic clk = 0, rst_ni = 0, pen_we = 0, valid = 0, shit = 0;
  logic [PW-1:0] pen_data = '0;
  logic core = 0;
  logic [AW-1:0] line = '0;
  logic [1:0] cls;
  logic [NC*ACW-1:0] totals;

  always #4 clk = ~clk;

  sit_intf_detector #(.NUM_CORES(NC), .ADDR_W(AW), .SETS(NS), .WAYS(NW),
    .ACC_W(ACW), .PEN_W(PW), .PEN_RST(8'd40)) i_sit_intf_detector (
    .clk_i(clk), .rst_ni(rst_ni), .pen_we_i(pen_we), .pen_data_i(pen_data),
    .acc_valid_i(valid), .acc_core_i(core), .acc_line_i(line),
    .acc_hit_i(shit), .class_o(cls), .totals_o(totals));

  int n_chk = 0, n_bad = 0, pen = 40, stamp = 0;
  int m_v [NC][NS][NW], m_t [NC][NS][NW], m_s [NC][NS][NW];
  int e_tot [NC];
  bit done = 0;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < NC; c++) begin
      e_tot[c] = 0;
      for (int s = 0; s < NS; s++) for (int w = 0; w < NW; w++) begin
        m_v[c][s][w] = 0; m_t[c][s][w] = 0; m_s[c][s][w] = 0;
      end
    end
  endtask

  // LRU model: returns 1 on shadow hit, updates the core's own set
  function automatic int model_look(int c, int ln);
    int s = ln % NS, t = ln / NS, hw = -1, vw = -1;
    stamp++;
    for (int w = 0; w < NW; w++) if (m_v[c][s][w] != 0 && m_t[c][s][w] == t) hw = w;
    if (hw >= 0) begin m_s[c][s][hw] = stamp; return 1; end
    for (int w = NW - 1; w >= 0; w--) if (m_v[c][s][w] == 0) vw = w;
    if (vw < 0) begin
      vw = 0;
      for (int w = 1; w < NW; w++) if (m_s[c][s][w] < m_s[c][s][vw]) vw = w;
    end
    m_v[c][s][vw] = 1; m_t[c][s][vw] = t; m_s[c][s][vw] = stamp;
    return 0;
  endfunction

  task automatic check_tot(string req);
    for (int c = 0; c < NC; c++) chk(req, int'(totals[c*ACW +: ACW]), e_tot[c]);
  endtask

  // drive at negedge, compare at the following negedge
  task automatic acc(int c, int ln, bit h, string req, int exp_cls = -1);
    int sh, ec;
    valid = 1; core = c[0]; line = AW'(ln); shit = h;
    sh = model_look(c, ln);
    ec = h ? 1 : (sh != 0 ? 2 : 3);
    if (ec == 2) e_tot[c] = (e_tot[c] + pen > MAXV) ? MAXV : e_tot[c] + pen;
    @(negedge clk);
    chk(req, int'(cls), ec);
    if (exp_cls >= 0) chk(req, ec, exp_cls);
    check_tot(req);
  endtask

  task automatic idle(string req);
    valid = 0;
    @(negedge clk);
    chk(req, int'(cls), 0);
    check_tot(req);
  endtask

  task automatic set_pen(int v);
    valid = 0; pen_we = 1; pen_data = PW'(v);
    @(negedge clk);
    pen_we = 0; pen = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf = 16'hACE1;
    model_reset();
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    chk("R1 class", int'(cls), 0);
    check_tot("R1 totals");

    // R10: line 0 -> set 0 tag 0; line 2 -> set 0 tag 1; line 4 -> set 0 tag 2
    acc(0, 0, 0, "R2 cold", 3);
    acc(0, 0, 0, "R3 interference", 2);
    acc(1, 0, 0, "R5 other core cold", 3);
    acc(0, 0, 0, "R5 owner still hits", 2);
    acc(0, 2, 1, "R4 shared hit shadow miss", 1);
    acc(0, 2, 0, "R4 allocated on hit", 2);
    acc(0, 0, 1, "R6 touch", 1);
    acc(0, 4, 0, "R6 fill evicts LRU", 3);
    acc(0, 0, 0, "R6 MRU kept", 2);
    acc(0, 2, 0, "R6 LRU evicted", 3);
    acc(1, 1, 0, "R10 set 1 cold", 3);
    acc(1, 0, 0, "R10 set 0 kept", 2);
    idle("R2 idle");

    set_pen(7);
    acc(1, 1, 0, "R8 new penalty", 2);
    acc(1, 1, 0, "R9 back-to-back", 2);
    acc(0, 0, 0, "R9 back-to-back other core", 2);
    set_pen(200);
    for (int i = 0; i < 7; i++) acc(0, 0, 0, "R7 saturation", 2);
    chk("R7 saturated", int'(totals[0 +: ACW]), MAXV);
    idle("R7 hold");

    valid = 0; rst_ni = 0;
    @(negedge clk);
    rst_ni = 1; pen = 40; model_reset();
    @(negedge clk);
    chk("R1 penalty after reset", int'(cls), 0);
    check_tot("R1 totals after reset");
    acc(0, 0, 0, "R1 shadow cleared", 3);
    acc(0, 0, 0, "R1 penalty reset value", 2);
    set_pen(3);

    for (int i = 0; i < 4000; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (lf[3:0] == 4'd0) idle("R2 sweep idle");
      else acc(int'(lf[4]), int'(lf[9:7]), lf[6] & lf[11], "R9 sweep");
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule